// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines and drives a single request line towards a processor. Each line is resynchronised into the local clock domain. The synchronised level is held in a pending vector, and that vector mirrors the lines: a bit is set while its line is high and clears as soon as the line drops. Nothing is latched, so a source keeps its request up until it is serviced at the source.

Software controls which lines may raise the request through an enable mask. It reaches the block over a plain 32-bit word bus made of an address, a write strobe, write data and combinational read data. The mask can be written and read back. The pending vector is visible, unmasked, through a separate read-only word. Two further word addresses accept writes and do nothing, so that software written for a clear-style register still runs. The request output is registered and is high whenever some enabled line is pending.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Bit i of the pending vector equals `irq_in[i]` as sampled two rising clock edges earlier. It drops as soon as the sampled input drops and is never held.
- R2: `irq_out` is a register. After each rising edge it equals the OR over all bits of (mask AND pending), using the values those held before that edge.
- R3: A write with `bus_we` high to byte address 0x04 loads `bus_wdata[N_IRQ-1:0]` into the mask at that rising edge.
- R4: While `bus_addr` is 0x04, `bus_rdata` shows the mask zero-extended to 32 bits. Bits at or above `N_IRQ` read as 0.
- R5: While `bus_addr` is 0x0C, `bus_rdata` shows the pending vector zero-extended, with no mask applied. Writes to 0x0C change nothing.
- R6: Writes to byte addresses 0x00 and 0x14 are accepted and change neither the mask, the pending vector nor `irq_out`.
- R7: Any address other than 0x04 and 0x0C reads as zero. Writes to it are ignored. This includes addresses that are not multiples of four, since only aligned 32-bit words exist.
- R8: While `rst_n` is low, and for the first two rising edges after it goes high, the mask, the pending vector and `irq_out` are all zero, and writes are ignored.
- R9: `bus_rdata` is combinational from `bus_addr` and the current register state. No read strobe and no wait cycle are involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally after two edges |
| irq_in | input | N_IRQ | Level-sensitive interrupt lines, asynchronous to `clk` |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A change on an interrupt line shows up on the pending read at the third sampling point after it is driven, because it passes two flops. It reaches `irq_out` one edge after that. A mask write is visible on read-back at the next sample and on `irq_out` one edge later. Read data is combinational, so it is checked in the same cycle the address is driven. The bench drives inputs on the falling edge and keeps a reference model that it advances at each rising edge from the requirements. It then compares read data straight after driving and `irq_out` at the next falling edge, so each result is sampled exactly when its latency says it is due. This includes the two dead edges after reset release.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  localparam int unsigned BUS_W = 32;

  // register word offsets (byte addresses)
  localparam logic [31:0] OFS_DUMMY_A = 32'h0000_0000;
  localparam logic [31:0] OFS_ENABLE  = 32'h0000_0004;
  localparam logic [31:0] OFS_PEND    = 32'h0000_000C;
  localparam logic [31:0] OFS_DUMMY_B = 32'h0000_0014;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_ENABLE = 2'd1,
    ACC_PEND   = 2'd2,
    ACC_DUMMY  = 2'd3
  } acc_e;

  // Unaligned addresses fall to ACC_NONE since only exact word offsets match.
  function automatic acc_e decode_acc(input logic [31:0] addr);
    case (addr)
      OFS_ENABLE:  decode_acc = ACC_ENABLE;
      OFS_PEND:    decode_acc = ACC_PEND;
      OFS_DUMMY_A: decode_acc = ACC_DUMMY;
      OFS_DUMMY_B: decode_acc = ACC_DUMMY;
      default:     decode_acc = ACC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lvl_irq_rst_sync.sv
module lvl_irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign dout[i] = chain_q[LAST];
  end

endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  input  logic [N_IRQ-1:0] pend,
  output logic [N_IRQ-1:0] mask,
  output logic [BUS_W-1:0] rdata
);

  acc_e             acc;
  logic             mask_en;
  logic [N_IRQ-1:0] mask_d;
  logic [N_IRQ-1:0] mask_q;

  always_comb begin
    acc     = decode_acc(32'(addr));
    mask_en = we && (acc == ACC_ENABLE);
    mask_d  = wdata[N_IRQ-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_comb begin
    case (acc)
      ACC_ENABLE: rdata = BUS_W'(mask_q);
      ACC_PEND:   rdata = BUS_W'(pend);
      default:    rdata = '0;
    endcase
  end

  assign mask = mask_q;

endmodule

// File: rtl/lvl_irq_eval.sv
module lvl_irq_eval #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] mask,
  input  logic [N_IRQ-1:0] pend,
  output logic             irq
);

  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = |(mask & pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_out
);

  localparam int unsigned SYNC_STAGES = 2;

  logic             srst_n;
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] mask_q;

  lvl_irq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lvl_irq_sync #(
    .WIDTH  (N_IRQ),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .din   (irq_in),
    .dout  (pend_q)
  );

  lvl_irq_regs #(
    .N_IRQ  (N_IRQ),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (srst_n),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .pend  (pend_q),
    .mask  (mask_q),
    .rdata (bus_rdata)
  );

  lvl_irq_eval #(
    .N_IRQ (N_IRQ)
  ) u_eval (
    .clk   (clk),
    .rst_n (srst_n),
    .mask  (mask_q),
    .pend  (pend_q),
    .irq   (irq_out)
  );

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              srst_n,
  input logic [N_IRQ-1:0]  irq_in,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              irq_out,
  input logic [N_IRQ-1:0]  mask_q,
  input logic [N_IRQ-1:0]  pend_q
);

  logic [1:0] warm_q;
  logic       at_enable;
  logic       at_pend;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      warm_q <= 2'd0;
    end else if (warm_q != 2'd3) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  assign at_enable = (32'(bus_addr) == OFS_ENABLE);
  assign at_pend   = (32'(bus_addr) == OFS_PEND);

  // R1
  pend_track_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (warm_q >= 2'd2) |-> (pend_q == $past(irq_in, 2)));

  // R2
  irq_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    irq_out == $past(|(mask_q & pend_q)));

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && at_enable) |=> (mask_q == $past(bus_wdata[N_IRQ-1:0])));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_we && !at_enable) |=> $stable(mask_q));

  // R4
  read_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_enable |-> (bus_rdata == BUS_W'(mask_q)));

  // R5
  read_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_pend |-> (bus_rdata == BUS_W'(pend_q)));

  // R7
  read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_enable && !at_pend) |-> (bus_rdata == '0));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_n) |-> ((mask_q == '0) && (pend_q == '0) && !irq_out));

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(
  .N_IRQ  (N_IRQ),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_n    (srst_n),
  .irq_in    (irq_in),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .mask_q    (mask_q),
  .pend_q    (pend_q)
);

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 32;
  localparam int AW         = 8;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  irq_in;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int checks;
  int errors;

  // reference state
  logic [N-1:0] m_s1, m_pend, m_mask;
  logic         m_irq;
  int           m_rel;

  lvl_irq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    if (a == 8'h04)      return 32'(m_mask);
    else if (a == 8'h0C) return 32'(m_pend);
    else                 return 32'h0;
  endfunction

  function automatic string read_tag(input logic [AW-1:0] a);
    if (a == 8'h04)      return "R4 R9";
    else if (a == 8'h0C) return "R5 R1 R9";
    else                 return "R7 R9";
  endfunction

  // one bus cycle: drive at falling edge, check read, advance model, check irq
  task automatic cyc(input logic [N-1:0] iv, input logic we, input logic [AW-1:0] a,
                     input logic [31:0] wd, input string tag);
    logic [31:0] er;
    irq_in    = iv;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = wd;
    #1;
    er = exp_read(a);
    chk(bus_rdata == er, {tag, " ", read_tag(a)}, bus_rdata, er);
    @(posedge clk);
    if (!rst_n) begin
      m_s1 = '0; m_pend = '0; m_mask = '0; m_irq = 1'b0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      m_irq  = |(m_mask & m_pend);
      m_pend = m_s1;
      m_s1   = iv;
      if (we && a == 8'h04) m_mask = wd[N-1:0];
    end
    @(negedge clk);
    chk(irq_out == m_irq, {tag, " R2"}, 32'(irq_out), 32'(m_irq));
  endtask

  function automatic logic [AW-1:0] pick_addr();
    case ($urandom % 8)
      0: return 8'h00;
      1, 2: return 8'h04;
      3, 4: return 8'h0C;
      5: return 8'h14;
      6: return 8'h08;
      default: return AW'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    m_s1 = '0; m_pend = '0; m_mask = '0; m_irq = 1'b0; m_rel = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    @(negedge clk);

    // R8: reset holds everything at zero, writes ignored
    repeat (3) cyc('1, 1'b1, 8'h04, 32'hFFFF_FFFF, "R8");
    cyc('1, 1'b0, 8'h0C, 32'h0, "R8");
    rst_n = 1'b1;
    cyc('1, 1'b1, 8'h04, 32'hFFFF_FFFF, "R8");
    cyc('1, 1'b1, 8'h04, 32'hFFFF_FFFF, "R8");
    cyc('0, 1'b0, 8'h04, 32'h0, "R8");
    cyc('0, 1'b0, 8'h0C, 32'h0, "R8");

    // R3: load single-bit mask
    cyc('0, 1'b1, 8'h04, 32'h0000_0001, "R3");
    cyc('0, 1'b0, 8'h04, 32'h0, "R3");

    // R5: unmasked line pends without raising irq
    repeat (4) cyc(32'h0000_0002, 1'b0, 8'h0C, 32'h0, "R5");

    // R1: enabled line raises, then clears without latching
    repeat (4) cyc(32'h0000_0003, 1'b0, 8'h0C, 32'h0, "R1");
    repeat (4) cyc(32'h0000_0000, 1'b0, 8'h0C, 32'h0, "R1");

    // R6: dummy addresses accept writes with no effect
    cyc(32'h0000_0001, 1'b1, 8'h00, 32'h0, "R6");
    cyc(32'h0000_0001, 1'b1, 8'h14, 32'h0, "R6");
    cyc(32'h0000_0001, 1'b1, 8'h0C, 32'h0, "R6");
    repeat (3) cyc(32'h0000_0001, 1'b0, 8'h04, 32'h0, "R6");

    // R7: unaligned and unlisted addresses
    cyc(32'h0000_0001, 1'b1, 8'h05, 32'h0, "R7");
    cyc(32'h0000_0001, 1'b1, 8'h08, 32'h0, "R7");
    cyc(32'h0000_0001, 1'b0, 8'h05, 32'h0, "R7");
    cyc(32'h0000_0001, 1'b0, 8'h10, 32'h0, "R7");
    cyc(32'h0000_0001, 1'b0, 8'h04, 32'h0, "R7");

    // R2: top bit with full mask, then mask cleared drops irq next edge
    cyc(32'h8000_0000, 1'b1, 8'h04, 32'hFFFF_FFFF, "R2");
    repeat (3) cyc(32'h8000_0000, 1'b0, 8'h0C, 32'h0, "R2");
    cyc(32'h8000_0000, 1'b1, 8'h04, 32'h0, "R2");
    repeat (2) cyc(32'h8000_0000, 1'b0, 8'h04, 32'h0, "R2");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] iv;
      logic [31:0]  wd;
      iv = ($urandom % 2) ? N'($urandom & $urandom & $urandom) : N'($urandom);
      wd = ($urandom % 2) ? ($urandom & $urandom) : $urandom;
      cyc(iv, 1'($urandom % 3 == 0), pick_addr(), wd, "RND");
    end

    summary();
    $finish;
  end

endmodule